// File: doc/BRIEF.md
# Staged Clock Divider and Parent-Select Configuration with Trigger Commit

This block holds the configuration of one peripheral clock path: which parent clock feeds it, a pre-divider, and a main divider whose divisor may carry fractional bits. Software writes new field values into shadow registers through a simple register port. Nothing reaches the clock path until software writes a 1 to a trigger bit. The pre-trigger moves the parent select and the pre-divider. The main trigger moves the main divider.

A trigger bit reads back as 1 while its commit is pending. It clears in the same edge that copies the shadow fields to the active outputs. That edge is the fourth input-clock edge counted while the clock gate is open. While the gate is closed the count does not advance, so a commit can wait forever. Each divider field stores the divisor minus one. In a fractional divider, the plus-one sits just above the fraction bits, so the output is the divisor in scaled units. A parent-select value that names no parent is refused: a flag is raised and the previous parent stays in use.

Top module: `clkcfg_commit`

## Requirements
- R1: After reset the shadow select reads 7 (no valid parent) and both shadow divider fields read 0. The active outputs are parent 0, pre-divisor 1 and scaled main divisor 4. Both trigger bits read 0 and parent_bad is 0.
- R2: Register address 0 holds the parent select in bits [2:0] and the pre-divider field in bits [11:8]. Address 1 holds the main divider field in bits [7:0], of which bits [1:0] are fraction. Address 2 holds the pre-trigger in bit 0 and the main trigger in bit 1. Bits outside these fields are dropped on write and read as 0. Reads of addresses 0 and 1 return the shadow values.
- R3: pre_div_out equals the committed pre-divider field plus 1.
- R4: div_out equals the committed main field plus 4, which is the divisor scaled by 4.
- R5: Writing 1 to a trigger bit makes it read 1. It returns to 0 on the fourth clock edge after the write edge while clk_on is 1, and the outputs change on that same edge and at no other time.
- R6: Edges with clk_on low do not advance a pending commit, and the outputs stay unchanged until four enabled edges have passed.
- R7: The pre-trigger updates only the parent select and the pre-divisor. The main trigger updates only the main divisor.
- R8: A committed select of 5 or more sets parent_bad and keeps the previous parent. A later valid commit clears parent_bad and applies the new parent.
- R9: Writing 0 to a trigger bit has no effect. Writing 1 while that trigger is busy neither restarts nor extends the commit.
- R10: A commit applies the shadow contents held before the completing edge. A shadow write sampled on that same edge is kept in the shadow only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_on | input | 1 | Clock gate is open |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational |
| sel_out | output | 3 | Active parent index |
| parent_bad | output | 1 | Last committed select was invalid |
| pre_div_out | output | 5 | Active pre-divisor |
| div_out | output | 9 | Active main divisor, scaled by 4 |

## Verification
A shadow write can land on the very edge that completes a commit of the same field. The bench provokes this by issuing a main trigger and then timing a divider write so that it is sampled on the fourth enabled edge. The check passes when div_out takes the older shadow value and a read of the register returns the newer one. A second commit is then issued, and it must deliver the newer value.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    typedef enum logic [1:0] {
        ADR_SELPRE = 2'd0,
        ADR_DIV    = 2'd1,
        ADR_TRIG   = 2'd2,
        ADR_NONE   = 2'd3
    } cfg_addr_e;

    localparam int TRIG_PRE  = 0;
    localparam int TRIG_MAIN = 1;
    localparam int N_TRIG    = 2;

    function automatic logic [31:0] field_get(logic [31:0] word, int sh, int wd);
        logic [31:0] mask;
        mask = (wd >= 32) ? 32'hFFFF_FFFF : ((32'h1 << wd) - 32'h1);
        return (word >> sh) & mask;
    endfunction

endpackage

// File: rtl/clkcfg_trig.sv
module clkcfg_trig #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic clk_on,
    output logic busy,
    output logic fire
);
    localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;

    logic [CW-1:0] cnt;

    assign fire = busy && clk_on && (cnt == CW'(LAT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            busy <= go;
            cnt  <= '0;
        end else if (clk_on) begin
            if (fire) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/clkcfg_shadow.sv
module clkcfg_shadow
    import clkcfg_pkg::*;
#(
    parameter int SEL_W   = 3,
    parameter int SEL_SH  = 0,
    parameter int PDIV_W  = 4,
    parameter int PDIV_SH = 8,
    parameter int DIV_W   = 8,
    parameter int DIV_SH  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_addr,
    input  logic [N_TRIG-1:0] busy,
    output logic [31:0]       rd_data,
    output logic [SEL_W-1:0]  sel_sh,
    output logic [PDIV_W-1:0] pdiv_sh,
    output logic [DIV_W-1:0]  div_sh
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_sh  <= '1;
            pdiv_sh <= '0;
            div_sh  <= '0;
        end else if (wr_en) begin
            case (cfg_addr_e'(wr_addr))
                ADR_SELPRE: begin
                    sel_sh  <= SEL_W'(field_get(wr_data, SEL_SH, SEL_W));
                    pdiv_sh <= PDIV_W'(field_get(wr_data, PDIV_SH, PDIV_W));
                end
                ADR_DIV: div_sh <= DIV_W'(field_get(wr_data, DIV_SH, DIV_W));
                default: ;
            endcase
        end
    end

    always_comb begin
        case (cfg_addr_e'(rd_addr))
            ADR_SELPRE: rd_data = (32'(sel_sh) << SEL_SH) | (32'(pdiv_sh) << PDIV_SH);
            ADR_DIV:    rd_data = 32'(div_sh) << DIV_SH;
            ADR_TRIG:   rd_data = 32'(busy);
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/clkcfg_commit.sv
module clkcfg_commit
    import clkcfg_pkg::*;
#(
    parameter int SEL_W    = 3,
    parameter int SEL_SH   = 0,
    parameter int N_PARENT = 5,
    parameter int PDIV_W   = 4,
    parameter int PDIV_SH  = 8,
    parameter int DIV_W    = 8,
    parameter int DIV_SH   = 0,
    parameter int FRAC_W   = 2,
    parameter int LAT      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_on,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic [SEL_W-1:0]  sel_out,
    output logic              parent_bad,
    output logic [PDIV_W:0]   pre_div_out,
    output logic [DIV_W:0]    div_out
);
    localparam logic [DIV_W:0] DIV_ONE = (DIV_W+1)'(1) << FRAC_W;

    logic [N_TRIG-1:0] go, busy, fire;
    logic [SEL_W-1:0]  sel_sh, sel_q;
    logic [PDIV_W-1:0] pdiv_sh, pdiv_q;
    logic [DIV_W-1:0]  div_sh, div_q;
    logic              bad_q;

    clkcfg_shadow #(
        .SEL_W(SEL_W), .SEL_SH(SEL_SH), .PDIV_W(PDIV_W), .PDIV_SH(PDIV_SH),
        .DIV_W(DIV_W), .DIV_SH(DIV_SH)
    ) u_shadow (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .busy(busy), .rd_data(rd_data),
        .sel_sh(sel_sh), .pdiv_sh(pdiv_sh), .div_sh(div_sh)
    );

    for (genvar g = 0; g < N_TRIG; g++) begin : g_trig
        assign go[g] = wr_en && (cfg_addr_e'(wr_addr) == ADR_TRIG) && wr_data[g];
        clkcfg_trig #(.LAT(LAT)) u_trig (
            .clk(clk), .rst(rst), .go(go[g]), .clk_on(clk_on),
            .busy(busy[g]), .fire(fire[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            bad_q  <= 1'b0;
            pdiv_q <= '0;
            div_q  <= '0;
        end else begin
            if (fire[TRIG_PRE]) begin
                pdiv_q <= pdiv_sh;
                if (32'(sel_sh) < N_PARENT) begin
                    sel_q <= sel_sh;
                    bad_q <= 1'b0;
                end else begin
                    bad_q <= 1'b1;
                end
            end
            if (fire[TRIG_MAIN]) div_q <= div_sh;
        end
    end

    assign sel_out     = sel_q;
    assign parent_bad  = bad_q;
    assign pre_div_out = {1'b0, pdiv_q} + (PDIV_W+1)'(1);
    assign div_out     = {1'b0, div_q} + DIV_ONE;
endmodule

// File: rtl/clkcfg_chk.sv
module clkcfg_chk #(
    parameter int SEL_W    = 3,
    parameter int N_PARENT = 5,
    parameter int PDIV_W   = 4,
    parameter int DIV_W    = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_on,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [31:0]       wr_data,
    input logic [1:0]        busy,
    input logic [SEL_W-1:0]  sel_out,
    input logic [PDIV_W:0]   pre_div_out,
    input logic [DIV_W:0]    div_out
);
    // R5: a trigger only goes busy after a write of 1 to it
    a_r5_pre_busy_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(busy[0]) |-> $past(wr_en && wr_addr == 2'd2 && wr_data[0]));
    a_r5_main_busy_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(busy[1]) |-> $past(wr_en && wr_addr == 2'd2 && wr_data[1]));
    // R6: a closed gate freezes the outputs
    a_r6_gated_hold: assert property (@(posedge clk) disable iff (rst)
        !clk_on |=> ($stable(div_out) && $stable(pre_div_out) && $stable(sel_out)));
    // R7: each output moves only when its own trigger completes
    a_r7_div_on_main: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_out) |-> $fell(busy[1]));
    a_r7_pre_on_pre: assert property (@(posedge clk) disable iff (rst)
        (!$stable(pre_div_out) || !$stable(sel_out)) |-> $fell(busy[0]));
    // R8: the active parent is always a valid one
    a_r8_sel_valid: assert property (@(posedge clk) disable iff (rst)
        32'(sel_out) < N_PARENT);
endmodule

bind clkcfg_commit clkcfg_chk #(
    .SEL_W(SEL_W), .N_PARENT(N_PARENT), .PDIV_W(PDIV_W), .DIV_W(DIV_W)
) u_chk (
    .clk(clk), .rst(rst), .clk_on(clk_on), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .sel_out(sel_out),
    .pre_div_out(pre_div_out), .div_out(div_out)
);

// File: tb/clkcfg_commit_tb.sv
module clkcfg_commit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_on = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [2:0]  sel_out;
    logic        parent_bad;
    logic [4:0]  pre_div_out;
    logic [8:0]  div_out;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    clkcfg_commit u_dut (
        .clk(clk), .rst(rst), .clk_on(clk_on), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .sel_out(sel_out),
        .parent_bad(parent_bad), .pre_div_out(pre_div_out), .div_out(div_out)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic nwait(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); chk("R1 shadow selpre", d, 32'h7);
        rd(2'd1, d); chk("R1 shadow div", d, 32'h0);
        rd(2'd2, d); chk("R1 trig idle", d, 32'h0);
        chk("R1 sel", sel_out, 0);
        chk("R1 pre", pre_div_out, 1);
        chk("R1 div", div_out, 4);
        chk("R1 bad", parent_bad, 0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(2'd0, 32'hFFFF_F503);
        rd(2'd0, d); chk("R2 selpre field map", d, 32'h503);
        wr(2'd1, 32'hABCD_002D);
        rd(2'd1, d); chk("R2 div field map", d, 32'h2D);
        chk("R10 no apply without trigger", div_out, 4);
    endtask

    task automatic t_pre_commit();
        logic [31:0] d;
        wr(2'd2, 32'h1);
        rd(2'd2, d); chk("R5 pre busy", d, 32'h1);
        nwait(3);
        chk("R5 sel before completion", sel_out, 0);
        nwait(1);
        chk("R5 sel applied", sel_out, 3);
        chk("R3 pre divisor", pre_div_out, 6);
        chk("R7 div untouched by pre", div_out, 4);
        rd(2'd2, d); chk("R5 pre cleared", d, 32'h0);
    endtask

    task automatic t_main_commit();
        wr(2'd2, 32'h2);
        nwait(4);
        chk("R4 scaled div", div_out, 49);
        chk("R7 sel untouched by main", sel_out, 3);
        chk("R7 pre untouched by main", pre_div_out, 6);
    endtask

    task automatic t_gated();
        logic [31:0] d;
        clk_on = 1'b0;
        wr(2'd1, 32'hFF);
        wr(2'd2, 32'h2);
        nwait(10);
        rd(2'd2, d); chk("R6 busy while gated", d, 32'h2);
        chk("R6 div held while gated", div_out, 49);
        clk_on = 1'b1;
        nwait(3);
        chk("R6 three enabled edges", div_out, 49);
        nwait(1);
        chk("R6 applied after gate opens", div_out, 259);
    endtask

    task automatic t_invalid();
        wr(2'd0, 32'h206);
        wr(2'd2, 32'h1);
        nwait(4);
        chk("R8 bad flag", parent_bad, 1);
        chk("R8 sel held", sel_out, 3);
        chk("R8 pre still applied", pre_div_out, 3);
        wr(2'd0, 32'h201);
        wr(2'd2, 32'h1);
        nwait(4);
        chk("R8 bad cleared", parent_bad, 0);
        chk("R8 new sel", sel_out, 1);
    endtask

    task automatic t_ignore();
        logic [31:0] d;
        wr(2'd1, 32'h10);
        wr(2'd2, 32'h0);
        rd(2'd2, d); chk("R9 zero write idle", d, 32'h0);
        nwait(5);
        chk("R9 zero write no apply", div_out, 259);
        wr(2'd2, 32'h2);
        wr(2'd2, 32'h2);
        nwait(2);
        rd(2'd2, d); chk("R9 rewrite no restart", d, 32'h0);
        chk("R9 applied on time", div_out, 20);
    endtask

    task automatic t_same_edge();
        logic [31:0] d;
        wr(2'd1, 32'h08);
        wr(2'd2, 32'h2);
        nwait(2);
        wr(2'd1, 32'h20);
        chk("R10 old shadow applied", div_out, 12);
        rd(2'd1, d); chk("R10 new shadow kept", d, 32'h20);
        wr(2'd2, 32'h2);
        nwait(4);
        chk("R10 new shadow on next commit", div_out, 36);
    endtask

    initial begin
        nwait(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_map();
        t_pre_commit();
        t_main_commit();
        t_gated();
        t_invalid();
        t_ignore();
        t_same_edge();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #20000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule